// File: doc/BRIEF.md
# Frame Ratio and Speed Mode Detector

This block watches a left/right frame clock that has already been brought into the master-clock domain. It measures how many master-clock cycles lie between successive rising edges of that frame clock. The measured period is matched against seven permitted ratios: 128, 192, 256, 384, 512, 768 and 1024 master clocks per frame. From the matched ratio the block picks an operating speed: single, double or quad.

A downstream audio datapath uses the result to choose its filter and serial-clock settings. It may only rely on the result while the valid flag is high. The flag rises once the same permitted ratio has been seen on two back-to-back frames. It drops at once when a frame's ratio is not permitted or does not match the locked ratio, and a one-cycle change pulse marks that event. The flag also drops when the frame clock stops.

An optional mode strap forces a speed. Only the ratios that the forced speed permits are then accepted. Without the strap, the lowest speed whose set contains the ratio is chosen.

Top module: `audio_ratio_detect`

## Requirements
- R1: After reset, `valid` and `ratio_changed` are 0, `ratio_code` is 7 (none) and `speed_mode` is 3 (none). Every time `valid` is 0, `ratio_code` reads 7 and `speed_mode` reads 3.
- R2: A frame period (master-clock cycles between two frame-clock rising edges) within ±TOL (default 2) of a permitted ratio maps to a ratio code: 0=128, 1=192, 2=256, 3=384, 4=512, 5=768, 6=1024. Any other period is illegal.
- R3: With the strap off, the speed code is 0 (single) for ratios 256 to 1024 and 1 (double) for ratios 128 and 192.
- R4: With the strap on, `speed_mode` equals `mode_force`, where 0 is single, 1 is double and 2 is quad. Single permits 256 to 1024, double permits 128 to 512, and quad permits 128 to 256. A ratio outside the forced set is illegal.
- R5: `valid` rises only after two consecutive frame periods have mapped to the same legal code. A single measured period never sets it.
- R6: A period measured as illegal forces `valid` to 0 and raises `ratio_changed` for that cycle.
- R7: While locked, a legal period with a different code drops `valid` and pulses `ratio_changed`. Two consecutive periods of the new code then lock again.
- R8: If no frame-clock rising edge occurs for ABSENT_LIMIT (default 2048) master-clock cycles, `valid` drops to 0 and no `ratio_changed` pulse is produced.
- R9: `ratio_changed` is never high on two consecutive cycles.
- R10: While `valid` stays high, `ratio_code` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_clk | input | 1 | Frame clock, already sampled in the master-clock domain |
| mode_force_en | input | 1 | Enables the speed-mode strap |
| mode_force | input | 2 | Forced speed: 0 single, 1 double, 2 quad |
| valid | output | 1 | Locked ratio and speed are usable |
| ratio_code | output | 3 | Locked ratio code (0..6), 7 when not valid |
| speed_mode | output | 2 | Speed code (0..2), 3 when not valid |
| ratio_changed | output | 1 | One-cycle pulse on an illegal or changed ratio |

## Verification
The hardest conditions to reach are at the edge of the tolerance window and at the strap boundary. There, a period only two or three cycles off its nominal value must flip the result between locked and illegal, and the same ratio must be accepted under one forced speed and refused under another. The bench sweeps every permitted ratio under every strap setting, at offsets just inside and just outside the window. Each run starts from reset and emits exactly three frames, so the lock decision comes from exactly two measured periods. Directed sequences cover the remaining cases: a locked stream that switches ratio part-way, a stream that turns illegal, and a frame clock that stops.

// File: rtl/ard_pkg.sv
package ard_pkg;

    localparam int unsigned NUM_RATIOS = 7;

    typedef enum logic [2:0] {
        RC_128  = 3'd0,
        RC_192  = 3'd1,
        RC_256  = 3'd2,
        RC_384  = 3'd3,
        RC_512  = 3'd4,
        RC_768  = 3'd5,
        RC_1024 = 3'd6,
        RC_NONE = 3'd7
    } ratio_e;

    typedef enum logic [1:0] {
        SPD_SINGLE = 2'd0,
        SPD_DOUBLE = 2'd1,
        SPD_QUAD   = 2'd2,
        SPD_NONE   = 2'd3
    } speed_e;

    typedef enum logic [1:0] {
        LK_SEEK   = 2'd0,
        LK_CAND   = 2'd1,
        LK_LOCKED = 2'd2
    } lock_state_e;

    typedef struct packed {
        logic   legal;
        ratio_e code;
        speed_e mode;
    } class_t;

    // nominal master clocks per frame for ratio index idx
    function automatic int unsigned nominal_ratio(int unsigned idx);
        case (idx)
            0:       return 128;
            1:       return 192;
            2:       return 256;
            3:       return 384;
            4:       return 512;
            5:       return 768;
            default: return 1024;
        endcase
    endfunction

    function automatic logic mode_accepts(speed_e m, ratio_e r);
        case (m)
            SPD_SINGLE: return (r >= RC_256) && (r <= RC_1024);
            SPD_DOUBLE: return (r <= RC_512);
            SPD_QUAD:   return (r <= RC_256);
            default:    return 1'b0;
        endcase
    endfunction

    function automatic speed_e lowest_mode(ratio_e r);
        return (r >= RC_256) ? SPD_SINGLE : SPD_DOUBLE;
    endfunction

endpackage

// File: rtl/frame_period_meter.sv
module frame_period_meter #(
    parameter int unsigned ABSENT_LIMIT = 2048,
    parameter int unsigned CNT_W        = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_in,
    output logic             period_done,
    output logic [CNT_W-1:0] period_len,
    output logic             absent
);
    localparam logic [CNT_W-1:0] LIMIT_M1 = CNT_W'(ABSENT_LIMIT - 1);

    logic             prev_q;
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rise;

    assign rise = frame_in & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q      <= 1'b0;
            armed_q     <= 1'b0;
            cnt_q       <= '0;
            period_done <= 1'b0;
            period_len  <= '0;
            absent      <= 1'b0;
        end else begin
            prev_q      <= frame_in;
            period_done <= 1'b0;
            absent      <= 1'b0;
            if (rise) begin
                cnt_q   <= '0;
                armed_q <= 1'b1;
                if (armed_q) begin
                    period_done <= 1'b1;
                    period_len  <= cnt_q + 1'b1;
                end
            end else if (cnt_q == LIMIT_M1) begin
                absent  <= armed_q;
                armed_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ratio_classifier.sv
module ratio_classifier
    import ard_pkg::*;
#(
    parameter int unsigned CNT_W = 12,
    parameter int unsigned TOL   = 2
) (
    input  logic [CNT_W-1:0] period,
    input  logic             force_en,
    input  logic [1:0]       force_mode,
    output class_t           cls
);
    logic [NUM_RATIOS-1:0] hit;

    for (genvar g = 0; g < NUM_RATIOS; g++) begin : g_win
        localparam int unsigned    NOM = nominal_ratio(g);
        localparam logic [CNT_W-1:0] LO  = CNT_W'(NOM - TOL);
        localparam logic [CNT_W-1:0] HI  = CNT_W'(NOM + TOL);
        assign hit[g] = (period >= LO) && (period <= HI);
    end

    ratio_e code;
    speed_e mode;

    always_comb begin
        code = RC_NONE;
        for (int i = 0; i < NUM_RATIOS; i++) begin
            if (hit[i]) code = ratio_e'(3'(i));
        end
        mode = force_en ? speed_e'(force_mode) : lowest_mode(code);
        cls.code  = code;
        cls.mode  = mode;
        cls.legal = (code != RC_NONE) && mode_accepts(mode, code);
    end

endmodule

// File: rtl/ratio_lock_tracker.sv
module ratio_lock_tracker
    import ard_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   period_done,
    input  logic   absent,
    input  class_t cls,
    output logic   valid,
    output ratio_e ratio_q,
    output speed_e speed_q,
    output logic   changed
);
    lock_state_e state_q;
    ratio_e      cand_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LK_SEEK;
            cand_q  <= RC_NONE;
            valid   <= 1'b0;
            ratio_q <= RC_NONE;
            speed_q <= SPD_NONE;
            changed <= 1'b0;
        end else begin
            changed <= 1'b0;
            if (absent) begin
                state_q <= LK_SEEK;
                valid   <= 1'b0;
                ratio_q <= RC_NONE;
                speed_q <= SPD_NONE;
            end else if (period_done) begin
                if (!cls.legal) begin
                    state_q <= LK_SEEK;
                    valid   <= 1'b0;
                    ratio_q <= RC_NONE;
                    speed_q <= SPD_NONE;
                    changed <= 1'b1;
                end else begin
                    case (state_q)
                        LK_SEEK: begin
                            cand_q  <= cls.code;
                            state_q <= LK_CAND;
                        end
                        LK_CAND: begin
                            if (cls.code == cand_q) begin
                                state_q <= LK_LOCKED;
                                valid   <= 1'b1;
                                ratio_q <= cls.code;
                                speed_q <= cls.mode;
                            end else begin
                                cand_q <= cls.code;
                            end
                        end
                        default: begin
                            if (cls.code == ratio_q) begin
                                speed_q <= cls.mode;
                            end else begin
                                state_q <= LK_CAND;
                                cand_q  <= cls.code;
                                valid   <= 1'b0;
                                ratio_q <= RC_NONE;
                                speed_q <= SPD_NONE;
                                changed <= 1'b1;
                            end
                        end
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/audio_ratio_detect.sv
module audio_ratio_detect
    import ard_pkg::*;
#(
    parameter int unsigned ABSENT_LIMIT = 2048,
    parameter int unsigned TOL          = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_clk,
    input  logic       mode_force_en,
    input  logic [1:0] mode_force,
    output logic       valid,
    output logic [2:0] ratio_code,
    output logic [1:0] speed_mode,
    output logic       ratio_changed
);
    localparam int unsigned CNT_W = $clog2(ABSENT_LIMIT) + 1;

    logic             period_done;
    logic [CNT_W-1:0] period_len;
    logic             absent;
    class_t           cls;
    ratio_e           ratio_q;
    speed_e           speed_q;

    frame_period_meter #(
        .ABSENT_LIMIT(ABSENT_LIMIT),
        .CNT_W       (CNT_W)
    ) u_meter (
        .clk        (clk),
        .rst        (rst),
        .frame_in   (frame_clk),
        .period_done(period_done),
        .period_len (period_len),
        .absent     (absent)
    );

    ratio_classifier #(
        .CNT_W(CNT_W),
        .TOL  (TOL)
    ) u_class (
        .period    (period_len),
        .force_en  (mode_force_en),
        .force_mode(mode_force),
        .cls       (cls)
    );

    ratio_lock_tracker u_lock (
        .clk        (clk),
        .rst        (rst),
        .period_done(period_done),
        .absent     (absent),
        .cls        (cls),
        .valid      (valid),
        .ratio_q    (ratio_q),
        .speed_q    (speed_q),
        .changed    (ratio_changed)
    );

    assign ratio_code = ratio_q;
    assign speed_mode = speed_q;

endmodule

// File: rtl/ard_checker.sv
module ard_checker #(
    parameter int unsigned ABSENT_LIMIT = 2048
) (
    input logic       clk,
    input logic       rst,
    input logic       frame_clk,
    input logic       valid,
    input logic [2:0] ratio_code,
    input logic [1:0] speed_mode,
    input logic       ratio_changed
);
    localparam int unsigned SAT = ABSENT_LIMIT + 3;
    localparam int unsigned W   = $clog2(SAT + 1);

    logic         prev_q;
    logic [W-1:0] quiet_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            quiet_q <= '0;
        end else begin
            prev_q <= frame_clk;
            if (frame_clk && !prev_q) quiet_q <= '0;
            else if (quiet_q != W'(SAT)) quiet_q <= quiet_q + 1'b1;
        end
    end

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!valid && !ratio_changed && ratio_code == 3'd7)); // R1

    AST_IDLE_CODES: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (ratio_code == 3'd7 && speed_mode == 2'd3)); // R1

    AST_VALID_CODES: assert property (@(posedge clk) disable iff (rst)
        valid |-> (ratio_code != 3'd7 && speed_mode != 2'd3)); // R2

    AST_CHANGE_DROPS: assert property (@(posedge clk) disable iff (rst)
        ratio_changed |-> !valid); // R6

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ratio_changed |=> !ratio_changed); // R9

    AST_LOCK_STABLE: assert property (@(posedge clk) disable iff (rst)
        (valid && $past(valid)) |-> (ratio_code == $past(ratio_code))); // R10

    AST_ABSENT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (quiet_q >= W'(ABSENT_LIMIT + 2)) |-> !valid); // R8

endmodule

bind audio_ratio_detect ard_checker #(.ABSENT_LIMIT(ABSENT_LIMIT)) u_ard_checker (
    .clk          (clk),
    .rst          (rst),
    .frame_clk    (frame_clk),
    .valid        (valid),
    .ratio_code   (ratio_code),
    .speed_mode   (speed_mode),
    .ratio_changed(ratio_changed)
);

// File: tb/tb_audio_ratio_detect.sv
module tb_audio_ratio_detect;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_clk = 1'b0;
    logic       mode_force_en = 1'b0;
    logic [1:0] mode_force = 2'd0;
    logic       valid;
    logic [2:0] ratio_code;
    logic [1:0] speed_mode;
    logic       ratio_changed;

    int checks = 0;
    int fails  = 0;
    int pulses = 0;

    always #5 clk = ~clk;

    audio_ratio_detect dut (
        .clk          (clk),
        .rst          (rst),
        .frame_clk    (frame_clk),
        .mode_force_en(mode_force_en),
        .mode_force   (mode_force),
        .valid        (valid),
        .ratio_code   (ratio_code),
        .speed_mode   (speed_mode),
        .ratio_changed(ratio_changed)
    );

    always @(negedge clk) if (!rst && ratio_changed) pulses++;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nom(input int i);
        case (i)
            0: return 128;   1: return 192;  2: return 256; 3: return 384;
            4: return 512;   5: return 768;  default: return 1024;
        endcase
    endfunction

    function automatic int exp_code(input int p);
        for (int i = 0; i < 7; i++)
            if (p >= nom(i) - 2 && p <= nom(i) + 2) return i;
        return 7;
    endfunction

    // fm: 0 no strap, 1..3 strap single/double/quad
    function automatic bit exp_legal(input int code, input int fm);
        int n;
        if (code == 7) return 0;
        n = nom(code);
        case (fm)
            1: return n >= 256;
            2: return n <= 512;
            3: return n <= 256;
            default: return 1;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        frame_clk = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_frame(input int p);
        frame_clk = 1'b1;
        repeat (p / 2) @(negedge clk);
        frame_clk = 1'b0;
        repeat (p - p / 2) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int p0;
        int c;
        int ps;
        do_reset();
        @(negedge clk);
        chk("R1 valid", valid, 0);
        chk("R1 ratio", ratio_code, 7);
        chk("R1 speed", speed_mode, 3);
        chk("R1 pulse", ratio_changed, 0);

        // sweep: every ratio, every strap, offsets at and past tolerance
        for (int fm = 0; fm < 4; fm++) begin
            for (int r = 0; r < 7; r++) begin
                for (int oi = 0; oi < 3; oi++) begin
                    int off;
                    int p;
                    int code;
                    bit leg;
                    int espd;
                    if (oi == 0 && fm != 0) continue;
                    off = (oi == 0) ? 0 : ((oi == 1) ? -3 : 2);
                    p = nom(r) + off;
                    mode_force_en = (fm != 0);
                    mode_force    = (fm != 0) ? 2'(fm - 1) : 2'd0;
                    do_reset();
                    repeat (3) run_frame(p);
                    code = exp_code(p);
                    leg  = exp_legal(code, fm);
                    espd = !leg ? 3 : (fm != 0 ? fm - 1 : (nom(code) >= 256 ? 0 : 1));
                    chk(fm == 0 ? "R2/R3 valid" : "R4 valid", valid, int'(leg));
                    chk("R2 ratio code", ratio_code, leg ? code : 7);
                    chk(fm == 0 ? "R3 speed" : "R4 speed", speed_mode, espd);
                end
            end
        end
        mode_force_en = 1'b0;
        mode_force    = 2'd0;

        // R5: one measured period is not enough
        do_reset();
        repeat (2) run_frame(256);
        chk("R5 no lock after one period", valid, 0);
        run_frame(256);
        chk("R5 lock after two periods", valid, 1);
        chk("R5 ratio", ratio_code, 2);

        // R7: locked ratio switches 256 -> 512
        p0 = pulses;
        repeat (2) run_frame(512);
        chk("R7 valid dropped", valid, 0);
        chk("R7 one pulse", pulses - p0, 1);
        run_frame(512);
        chk("R7 relock", valid, 1);
        chk("R7 new ratio", ratio_code, 4);
        chk("R7 speed", speed_mode, 0);

        // R6: locked 384 then illegal 300
        do_reset();
        repeat (3) run_frame(384);
        chk("R6 locked first", valid, 1);
        p0 = pulses;
        repeat (2) run_frame(300);
        chk("R6 valid dropped", valid, 0);
        chk("R6 pulse", pulses - p0, 1);
        chk("R6 ratio none", ratio_code, 7);

        // R8: frame clock stops
        do_reset();
        repeat (3) run_frame(128);
        chk("R8 locked first", valid, 1);
        chk("R3 speed 128", speed_mode, 1);
        p0 = pulses;
        frame_clk = 1'b0;
        repeat (1900) @(negedge clk);
        chk("R8 still valid before limit", valid, 1);
        repeat (200) @(negedge clk);
        chk("R8 valid cleared", valid, 0);
        chk("R8 no pulse", pulses - p0, 0);
        chk("R8 speed none", speed_mode, 3);

        // R9: repeated illegal frames give separate single pulses
        do_reset();
        p0 = pulses;
        repeat (4) run_frame(100);
        chk("R9 one pulse per illegal period", pulses - p0, 3);

        // R10: long locked run keeps code
        do_reset();
        repeat (3) run_frame(766);
        c = ratio_code;
        ps = pulses;
        repeat (3) run_frame(770);
        chk("R10 code held", ratio_code, c);
        chk("R10 still valid", valid, 1);
        chk("R10 no pulse", pulses - ps, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule